// File: doc/BRIEF.md
# Periodic Down-Counter Tick Timer

This block is a small timer peripheral for a processor subsystem. Software programs a 24-bit reload value, clears the counter and enables it. From then on the counter steps down by one on each tick, from the reload value to zero and back again, so that a reload value of N gives a period of N+1 ticks. Each tick comes either from the bus clock itself or from a slower precision reference clock. The reference clock is brought into the bus clock domain and divided by four, and the result is a one-cycle tick enable. No derived clock is built.

Each time the counter steps from one to zero, a sticky flag in the control register is set. A polling loop can watch that flag to detect the end of a period. When interrupts are enabled, the same event also produces a one-cycle interrupt request pulse. Software reads the timer through three word registers on a plain address/strobe/data bus:

- control and status at offset 0x0
- reload at offset 0x4
- current value at offset 0x8

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current registers all read 0, the counter is stopped and `irq_o` is low.
- R2: The registers are decoded at offsets 0x0 (control), 0x4 (reload) and 0x8 (current), and any other offset reads 0. The control register fields are:
  - bit 0: run enable
  - bit 1: interrupt enable
  - bit 2: tick source (1 = bus clock, 0 = reference clock divided by four)
  - bit 16: the read-only wrap flag

  All other control bits read 0.
- R3: The reload and current registers keep 24 bits. Write data bits 31..24 are ignored and those bits always read 0.
- R4: With source 1 and the timer enabled, the counter changes on every bus clock cycle. A non-zero value decrements. A value of 0 loads the reload value. The sequence is N, N-1, …, 0, N, …
- R5: With source 0, the counter advances exactly once per four rising edges of `prec_clk_i` and does not advance on other bus clock cycles.
- R6: The wrap flag is set when the counter steps from 1 to 0, and it stays set until it is cleared.
- R7: A control register read (with `bus_re_i` high) returns the flag value held before the read and then clears the flag. If a wrap happens in the same cycle as that read, the flag ends up set.
- R8: Any write to the current register clears the counter and the wrap flag, whatever the data is. This write takes priority over a tick in the same cycle.
- R9: `irq_o` is a one-cycle pulse in the cycle in which the wrap flag becomes set. It occurs only while the interrupt enable is 1.
- R10: With a reload value of 0, an enabled counter stays at 0 and never sets the flag or raises `irq_o`.
- R11: With the run enable at 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prec_clk_i | input | 1 | Precision reference clock, sampled in the bus clock domain |
| bus_addr_i | input | 4 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (a control register read clears the flag) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The wrap flag has a set source (the counter stepping from 1 to 0) and a clear source (a control register read), and the two can fall in the same bus cycle. The bench provokes this case with a reload value of 3 and the bus clock as source. It counts the cycles from the enabling write and issues the control read in the exact cycle that ends with the wrap. It then judges two results:

- the read must return the old flag value of 0
- a later peek without the read strobe must show the flag set

A second overlap, between a current register write and a tick, is judged by checking that the counter reads 0 after the write and reloads only on the following tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Register byte offsets
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_RLD  = 4;
  localparam int unsigned OFF_CUR  = 8;

  // Control register bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;

  // Value the counter takes on an enabled tick
  function automatic logic [31:0] next_count(input logic [31:0] cur,
                                             input logic [31:0] rld);
    if (cur == 32'd0) return rld;
    return cur - 32'd1;
  endfunction

  // A tick at this value produces the step to zero
  function automatic logic is_wrap(input logic [31:0] cur);
    return cur == 32'd1;
  endfunction

endpackage

// File: rtl/tick_timer_src.sv
module tick_timer_src #(
  parameter int unsigned DIV  = 4,
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prec_clk_i,
  input  logic en_i,
  input  logic use_sys_i,
  output logic tick_o
);

  // Synchronizer chain plus one extra stage for edge detection
  logic [SYNC:0] sync_q;
  logic          rise_w;
  logic          stb_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-1:0], prec_clk_i};
  end

  assign rise_w = sync_q[SYNC-1] & ~sync_q[SYNC];

  generate
    if (DIV <= 1) begin : g_nodiv
      assign stb_w = rise_w;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          div_q <= '0;
        end else if (rise_w) begin
          if (div_q == LAST) div_q <= '0;
          else               div_q <= div_q + 1'b1;
        end
      end

      assign stb_w = rise_w && (div_q == LAST);
    end
  endgenerate

  assign tick_o = en_i & (use_sys_i | stb_w);

endmodule

// File: rtl/tick_timer_cnt.sv
module tick_timer_cnt
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= CNT_W'(next_count(32'(cnt_q), 32'(reload_i)));
  end

  // A clear in the same cycle suppresses the wrap
  assign wrap_o = tick_i && !clear_i && is_wrap(32'(cnt_q));
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_wr_o,
  output logic              ctrl_rd_o,
  output logic              flag_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFF_RLD);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CUR);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             irq_q;
  logic             ctrl_wr_w;
  logic             rld_wr_w;

  assign ctrl_wr_w = bus_we_i && (bus_addr_i == A_CTRL);
  assign rld_wr_w  = bus_we_i && (bus_addr_i == A_RLD);
  assign cur_wr_o  = bus_we_i && (bus_addr_i == A_CUR);
  assign ctrl_rd_o = bus_re_i && (bus_addr_i == A_CTRL);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_w) begin
      ctrl_q.en  <= bus_wdata_i[BIT_EN];
      ctrl_q.ie  <= bus_wdata_i[BIT_IE];
      ctrl_q.src <= bus_wdata_i[BIT_SRC];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       reload_q <= '0;
    else if (rld_wr_w) reload_q <= bus_wdata_i[CNT_W-1:0];
  end

  // Set has priority over the read clear
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (wrap_i)                 flag_q <= 1'b1;
    else if (ctrl_rd_o || cur_wr_o)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap_i && ctrl_q.ie;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL) begin
      bus_rdata_o[BIT_EN]   = ctrl_q.en;
      bus_rdata_o[BIT_IE]   = ctrl_q.ie;
      bus_rdata_o[BIT_SRC]  = ctrl_q.src;
      bus_rdata_o[BIT_FLAG] = flag_q;
    end else if (bus_addr_i == A_RLD) begin
      bus_rdata_o[CNT_W-1:0] = reload_q;
    end else if (bus_addr_i == A_CUR) begin
      bus_rdata_o[CNT_W-1:0] = cnt_i;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CNT_W];

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned PREC_DIV  = 4,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prec_clk_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  // Named internal events, also used by the bound checker
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_w;
  logic             tick_w;
  logic             wrap_w;
  logic             cur_wr_w;
  logic             ctrl_rd_w;
  logic             flag_w;
  logic             ie_w;

  assign ie_w = ctrl_w.ie;

  tick_timer_src #(
    .DIV  (PREC_DIV),
    .SYNC (SYNC_STG)
  ) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prec_clk_i (prec_clk_i),
    .en_i       (ctrl_w.en),
    .use_sys_i  (ctrl_w.src),
    .tick_o     (tick_w)
  );

  tick_timer_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .clear_i  (cur_wr_w),
    .reload_i (reload_w),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  tick_timer_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_i       (cnt_w),
    .wrap_i      (wrap_w),
    .ctrl_o      (ctrl_w),
    .reload_o    (reload_w),
    .cur_wr_o    (cur_wr_w),
    .ctrl_rd_o   (ctrl_rd_w),
    .flag_o      (flag_w),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_w,
  input logic              wrap_w,
  input logic              cur_wr_w,
  input logic              ctrl_rd_w,
  input logic              ie_w,
  input logic              flag_w,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  reload_w,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o
);

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !cur_wr_w && cnt_w != '0) |=> (cnt_w == $past(cnt_w) - 1'b1)); // R4

  AST_ZERO_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !cur_wr_w && cnt_w == '0) |=> (cnt_w == $past(reload_w))); // R10

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_w |=> flag_w); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_w && !ctrl_rd_w && !cur_wr_w) |=> flag_w); // R6

  AST_CUR_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr_w |=> (cnt_w == '0 && !flag_w)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_w && !cur_wr_w) |=> $stable(cnt_w)); // R11

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ie_w) && flag_w)); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(OFF_RLD) || bus_addr_i == ADDR_W'(OFF_CUR))
      |-> ((bus_rdata_o >> CNT_W) == '0)); // R3

endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_w      (tick_w),
  .wrap_w      (wrap_w),
  .cur_wr_w    (cur_wr_w),
  .ctrl_rd_w   (ctrl_rd_w),
  .ie_w        (ie_w),
  .flag_w      (flag_w),
  .irq_o       (irq_o),
  .cnt_w       (cnt_w),
  .reload_w    (reload_w),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_RLD  = 4'h4;
  localparam logic [3:0] A_CUR  = 4'h8;
  localparam logic [3:0] A_BAD  = 4'hC;
  localparam logic [31:0] FLAG  = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prec_clk = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tick_timer dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .prec_clk_i  (prec_clk),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_re_i    (re),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a; re = 1'b0;
    #1 d = rdata;
  endtask

  // Stop, set reload, clear counter, start with the given control value
  task automatic start(input logic [23:0] n, input logic [31:0] c);
    wr(A_CTRL, 32'h0);
    wr(A_RLD, {8'h0, n});
    wr(A_CUR, 32'h0);
    wr(A_CTRL, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    peek(A_RLD, v);  check("R1 reload", v, 32'h0);
    peek(A_CUR, v);  check("R1 current", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    peek(A_CUR, v);  check("R1 stopped", v, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_RLD, 32'hFFAB_CDEF);
    peek(A_RLD, v);  check("R3 reload mask", v, 32'h00AB_CDEF);
    wr(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, v); check("R2 ctrl fields", v, 32'h0000_0007);
    peek(A_BAD, v);  check("R2 unmapped", v, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'hFFFF_FFFF);
    peek(A_CUR, v);  check("R3 current upper", v & 32'hFF00_0000, 32'h0);
  endtask

  task automatic t_sequence();
    logic [31:0] v;
    logic [23:0] e;
    start(24'd3, 32'h5);
    e = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      e = (e == 0) ? 24'd3 : e - 1'b1;
      peek(A_CUR, v);
      check("R4 sequence", v, {8'h0, e});
    end
  endtask

  task automatic t_flag_clear();
    logic [31:0] v;
    bit seen = 0;
    start(24'd2, 32'h5);
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      peek(A_CTRL, v);
      if (v[16]) seen = 1;
    end
    check("R6 flag set", {31'h0, seen}, 32'h1);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    peek(A_CTRL, v); check("R6 flag sticky", v, FLAG);
    rd(A_CTRL, v);   check("R7 read returns flag", v, FLAG);
    rd(A_CTRL, v);   check("R7 read cleared flag", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    logic [23:0] e, p;
    bit any;
    start(24'd2, 32'h7);
    e = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      p = e;
      e = (e == 0) ? 24'd2 : e - 1'b1;
      peek(A_CUR, v);
      check("R4 irq run count", v, {8'h0, e});
      check("R9 irq pulse", {31'h0, irq}, {31'h0, (p == 24'd1)});
    end
    start(24'd2, 32'h5);
    any = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq) any = 1;
    end
    check("R9 no irq when disabled", {31'h0, any}, 32'h0);
    peek(A_CTRL, v); check("R9 flag still set", v & FLAG, FLAG);
  endtask

  task automatic t_cur_write();
    logic [31:0] v;
    start(24'd5, 32'h5);
    repeat (10) @(negedge clk);
    peek(A_CTRL, v); check("R8 flag before write", v & FLAG, FLAG);
    wr(A_CUR, 32'hDEAD_BEEF);
    peek(A_CUR, v);  check("R8 cleared counter", v, 32'h0);
    peek(A_CTRL, v); check("R8 cleared flag", v & FLAG, 32'h0);
    @(negedge clk);
    peek(A_CUR, v);  check("R4 reload after clear", v, 32'd5);
  endtask

  task automatic t_zero_reload();
    logic [31:0] v;
    bit bad = 0;
    start(24'd0, 32'h0);
    rd(A_CTRL, v);
    wr(A_CTRL, 32'h7);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      peek(A_CUR, v);
      if (v != 0 || irq) bad = 1;
    end
    check("R10 stays zero", {31'h0, bad}, 32'h0);
    peek(A_CTRL, v); check("R10 no flag", v, 32'h7);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    start(24'd50, 32'h5);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0);
    peek(A_CUR, v);  check("R11 value at stop", v, 32'd44);
    repeat (6) @(negedge clk);
    peek(A_CUR, v);  check("R11 holds", v, 32'd44);
  endtask

  task automatic t_precision();
    logic [31:0] v;
    start(24'd100, 32'h1);
    repeat (10) @(negedge clk);
    peek(A_CUR, v);  check("R5 no bus clock ticks", v, 32'h0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); prec_clk = 1'b1;
      repeat (3) @(negedge clk);
      prec_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    peek(A_CUR, v);  check("R5 four ticks from sixteen edges", v, 32'd97);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_overlap();
    logic [31:0] v;
    start(24'd3, 32'h5);
    repeat (2) @(negedge clk);
    rd(A_CTRL, v);   check("R7 read in wrap cycle", v, 32'h5);
    peek(A_CTRL, v); check("R7 set wins over clear", v, FLAG | 32'h5);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_precision();
    t_regmap();
    t_sequence();
    t_flag_clear();
    t_irq();
    t_cur_write();
    t_zero_reload();
    t_hold();
    t_overlap();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule